// File: doc/BRIEF.md
# Edge-Selectable External Event Counter

This block counts pulses arriving on an asynchronous event pin and compares the running count against a programmable compare value. Software picks which transition of the pin counts as an event: the rising edge or the falling edge. The pin is first brought into the system clock domain by a short synchronizer chain. Edges are then detected on the synchronized level.

A small control state machine has two states. `ST_HALT` is entered at reset and whenever the enable input is low. `ST_RUN` is entered through the `START` transition when the enable is high. The `STOP` transition returns to `ST_HALT` when the enable falls. While halted, the count is held at 00h and edges are discarded. While running, each valid edge either advances the count by one, or, if the count already equals the compare value, returns it to 00h. In that second case the block raises a single-clock interrupt request. The result is a repeating interrupt once every compare+1 valid edges.

Top module: `edge_event_counter`

## Requirements
- R1: While running, a valid edge with the count not equal to the compare value raises the count by exactly one. The count never changes in any way other than +1 or a return to 00h.
- R2: An edge-select value of 01h makes the rising edge of the event pin valid. Any other value, including 00h, makes the falling edge valid.
- R3: While running, a valid edge arriving when the count equals the compare value sets the count to 00h and raises the interrupt request.
- R4: The interrupt repeats on every match, so compare value N gives one interrupt per N+1 valid edges. Compare 00h interrupts on every valid edge, and compare FFh interrupts on every 256th.
- R5: The interrupt request is high for exactly one clock, in the same cycle that the count first reads 00h.
- R6: With the enable low, the count reads 00h one clock later and stays there, no interrupt is raised, and edges are ignored. Counting resumes from 00h once the enable is high again.
- R7: If the compare value is set below the current count, the count keeps rising, wraps from FFh to 00h with no interrupt, and later matches the new value.
- R8: The pin passes through two synchronizer flops. A valid pin transition shows on the count output three clock edges later, and each pin level must last at least two clocks.
- R9: During and after reset the count reads 00h, the interrupt is low and the state machine is in `ST_HALT`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_pin | input | 1 | Asynchronous external event input |
| edge_sel | input | 8 | 01h: rising edge valid; any other value: falling edge valid |
| cmp_val | input | 8 | Compare value, 00h to FFh |
| run_en | input | 1 | Counting enable |
| count_o | output | 8 | Current count |
| irq_o | output | 1 | One-clock interrupt request on compare match |

## Verification
The following properties are checked on every cycle:
- The count only ever steps by one or returns to zero.
- Every interrupt follows a cycle in which the count equalled the compare value, and coincides with a zero count.
- An interrupt never lasts two cycles.
- A low enable forces zero with no interrupt.
- A wrap from FFh to 00h under a different compare value raises no interrupt.

Some behaviour can only be shown by the bench's scenarios, which compare against an independent model of the pin history:
- Edge polarity selection.
- The exact interrupt period for compare 00h, FFh and random values.
- The three-clock pin-to-count latency.
- The ignoring of edges while disabled.

// File: rtl/eec_pkg.sv
package eec_pkg;
    localparam int CNT_W = 8;
    localparam int SEL_W = 8;
    localparam logic [SEL_W-1:0] SEL_RISE = 8'h01;

    typedef enum logic {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } ctrl_state_t;
endpackage

// File: rtl/eec_sync.sv
module eec_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[0] <= 1'b0;
                else        chain_q[0] <= din;
            end
        end else begin : g_rest
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[g] <= 1'b0;
                else        chain_q[g] <= chain_q[g-1];
            end
        end
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/eec_edge_det.sv
module eec_edge_det
    import eec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             level,
    input  logic [SEL_W-1:0] edge_sel,
    output logic             valid_edge
);
    logic prev_q;
    logic pick_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level;
    end

    always_comb begin
        pick_rise  = (edge_sel == SEL_RISE);
        valid_edge = pick_rise ? (level & ~prev_q) : (~level & prev_q);
    end
endmodule

// File: rtl/eec_ctrl.sv
module eec_ctrl
    import eec_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        run_en,
    output logic        counting,
    output logic        force_zero,
    output ctrl_state_t state
);
    ctrl_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: if (run_en)  state_d = ST_RUN;   // START
            ST_RUN:  if (!run_en) state_d = ST_HALT;  // STOP
            default: state_d = ST_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    always_comb begin
        counting   = 1'b0;
        force_zero = 1'b1;
        unique case (state_q)
            ST_HALT: begin
                counting   = 1'b0;
                force_zero = 1'b1;
            end
            ST_RUN: begin
                counting   = run_en;
                force_zero = !run_en;
            end
            default: begin
                counting   = 1'b0;
                force_zero = 1'b1;
            end
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/eec_counter.sv
module eec_counter
    import eec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [CNT_W-1:0] cmp_val,
    output logic [CNT_W-1:0] count,
    output logic             irq
);
    logic [CNT_W-1:0] cnt_q;
    logic             irq_q;
    logic             hit;

    assign hit = (cnt_q == cmp_val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            irq_q <= 1'b0;
        end else if (clear) begin
            cnt_q <= '0;
            irq_q <= 1'b0;
        end else if (step) begin
            cnt_q <= hit ? '0 : cnt_q + 1'b1;
            irq_q <= hit;
        end else begin
            irq_q <= 1'b0;
        end
    end

    assign count = cnt_q;
    assign irq   = irq_q;
endmodule

// File: rtl/edge_event_counter.sv
module edge_event_counter
    import eec_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_pin,
    input  logic [SEL_W-1:0] edge_sel,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             run_en,
    output logic [CNT_W-1:0] count_o,
    output logic             irq_o
);
    logic        evt_sync;
    logic        valid_edge;
    logic        counting;
    logic        force_zero;
    ctrl_state_t state;

    eec_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (evt_pin),
        .dout (evt_sync)
    );

    eec_edge_det u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .level     (evt_sync),
        .edge_sel  (edge_sel),
        .valid_edge(valid_edge)
    );

    eec_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .counting  (counting),
        .force_zero(force_zero),
        .state     (state)
    );

    eec_counter u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (force_zero),
        .step   (counting & valid_edge),
        .cmp_val(cmp_val),
        .count  (count_o),
        .irq    (irq_o)
    );
endmodule

// File: rtl/eec_checker.sv
module eec_checker
    import eec_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             run_en,
    input logic [CNT_W-1:0] cmp_val,
    input logic [CNT_W-1:0] count_o,
    input logic             irq_o
);
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o != $past(count_o)) |-> (count_o == $past(count_o) + 1'b1 || count_o == '0)); // R1
    AST_IRQ_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ($past(count_o) == $past(cmp_val))); // R3
    AST_IRQ_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (count_o == '0)); // R5
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o); // R5
    AST_HALT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (count_o == '0 && !irq_o)); // R6
    AST_WRAP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(count_o) == '1 && count_o == '0 && $past(cmp_val) != '1) |-> !irq_o); // R7
endmodule

bind edge_event_counter eec_checker u_eec_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_en (run_en),
    .cmp_val(cmp_val),
    .count_o(count_o),
    .irq_o  (irq_o)
);

// File: tb/test_edge_event_counter.sv
module test_edge_event_counter;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       evt_pin = 1'b0;
    logic [7:0] edge_sel = 8'h01;
    logic [7:0] cmp_val = 8'h00;
    logic       run_en = 1'b0;
    logic [7:0] count_o;
    logic       irq_o;

    int checks = 0;
    int fails = 0;
    int exp_cnt = 0;
    int exp_irq = 0;
    int seen_irq = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    edge_event_counter i_edge_event_counter (
        .clk(clk), .rst_n(rst_n), .evt_pin(evt_pin), .edge_sel(edge_sel),
        .cmp_val(cmp_val), .run_en(run_en), .count_o(count_o), .irq_o(irq_o)
    );

    function automatic int next_cnt(int c, int cmp);
        return (c == cmp) ? 0 : ((c + 1) % 256);
    endfunction

    function automatic bit is_valid(logic [7:0] sel, bit old_l, bit new_l);
        return (sel == 8'h01) ? (!old_l && new_l) : (old_l && !new_l);
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        if (irq_o) seen_irq++;
    endtask

    // drive one pin level, hold it 4 clocks, then compare with the model
    task automatic set_pin(bit v, string req);
        bit old_l = evt_pin;
        evt_pin = v;
        if (run_en && is_valid(edge_sel, old_l, v)) begin
            if (exp_cnt == int'(cmp_val)) exp_irq++;
            exp_cnt = next_cnt(exp_cnt, int'(cmp_val));
        end
        repeat (4) tick();
        check({req, " count"}, int'(count_o), exp_cnt);
        check({req, " irq total"}, seen_irq, exp_irq);
    endtask

    task automatic pulses(int n, string req);
        for (int i = 0; i < n; i++) begin
            set_pin(1'b1, req);
            set_pin(1'b0, req);
        end
    endtask

    task automatic set_enable(bit e);
        run_en = e;
        repeat (2) tick();
        if (!e) exp_cnt = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        process::self().srandom(32'h5EED_1234);
        repeat (3) @(negedge clk);
        check("R9 count in reset", int'(count_o), 0);
        check("R9 irq in reset", int'(irq_o), 0);
        rst_n = 1'b1;
        repeat (2) tick();
        check("R9 count after reset", int'(count_o), 0);

        // R8 latency: rising edge visible on the 3rd negedge after the change
        edge_sel = 8'h01; cmp_val = 8'd50;
        set_enable(1'b1);
        evt_pin = 1'b1;
        tick(); tick();
        check("R8 no change before 3 edges", int'(count_o), 0);
        tick();
        check("R8 change at 3rd edge", int'(count_o), 1);
        exp_cnt = 1;
        tick();
        set_pin(1'b0, "R2 falling ignored under rising select");
        set_enable(1'b0);
        check("R6 disable clears", int'(count_o), 0);

        // R1/R3/R4 rising edges, compare 3
        cmp_val = 8'd3;
        set_enable(1'b1);
        pulses(10, "R4 cmp3 rising");

        // R2 falling polarity with another select value, R4 compare 0
        set_enable(1'b0);
        edge_sel = 8'h00; cmp_val = 8'd0;
        set_enable(1'b1);
        pulses(5, "R4 cmp0 falling");
        edge_sel = 8'h7E;
        pulses(3, "R2 other sel falls");

        // R6 edges ignored while disabled
        set_enable(1'b0);
        pulses(4, "R6 disabled");
        edge_sel = 8'h01; cmp_val = 8'd5;
        set_enable(1'b1);
        pulses(3, "R6 resume from zero");

        // R4 compare FFh full period
        set_enable(1'b0);
        cmp_val = 8'hFF;
        set_enable(1'b1);
        pulses(258, "R4 cmpFF");

        // R7 compare rewritten below count
        set_enable(1'b0);
        cmp_val = 8'd20;
        set_enable(1'b1);
        pulses(10, "R7 before rewrite");
        cmp_val = 8'd3;
        pulses(252, "R7 wrap then match");

        // random mix, R1/R2/R3
        for (int k = 0; k < 40; k++) begin
            set_enable(1'b0);
            cmp_val = 8'($urandom_range(0, 12));
            edge_sel = ($urandom_range(0, 1) == 1) ? 8'h01 : 8'($urandom_range(2, 255));
            set_enable(1'b1);
            pulses(int'($urandom_range(1, 30)), "R3 random");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule